// File: doc/BRIEF.md
# Dual-Channel Spark Output Router

This block takes two ignition timing pulses from an engine controller and steers each one onto one of eight spark outputs. The controller fires the two channels in turn. Each channel has its own 3-bit binary selector, and either channel can reach any of the eight outputs. When both selectors point at the same output, that output carries the OR of the two pulses.

A 2-bit mirror field sets up wasted-spark operation for 4, 6 or 8 cylinders. In a wasted-spark mode an upper group of outputs repeats the lower group, and the repeated value replaces whatever the decoders would drive on those outputs. Outputs outside the mirrored group keep their decoder value.

An active-high disable input forces every output inactive. Board logic pulls this input high at power-up, so the spark outputs stay quiet until the controller has written valid routing and drives the input low.

The whole path is combinational, with no register anywhere. A pulse edge, a selector change or a mode change reaches the outputs in the same time step, so the controller's sub-microsecond spark resolution is kept.

Top module: `spark_router`

## Requirements
- R1: With mirror code 00 and disable low, pulse A appears on output index `sel_a_i` (code 000 is output 0, code 111 is output 7), and only there when pulse B is low.
- R2: With mirror code 00 and disable low, pulse B appears on output index `sel_b_i` with the same encoding, independently of `sel_a_i`.
- R3: When both selectors hold the same code, that output is the OR of the two pulses.
- R4: Mirror code 00 (coil-on-plug) alters no output, and at most two outputs are high at once.
- R5: Mirror code 01 (4-cylinder): outputs 2 and 3 equal outputs 0 and 1.
- R6: Mirror code 10 (6-cylinder): outputs 3, 4 and 5 equal outputs 0, 1 and 2.
- R7: Mirror code 11 (8-cylinder): outputs 4 to 7 equal outputs 0 to 3.
- R8: A mirrored output takes its source value and ignores its own decoder value. Outputs above the mirrored group (4 to 7 in 4-cylinder mode, 6 and 7 in 6-cylinder mode) keep their decoder value.
- R9: While `out_dis_i` is high, all eight outputs are low, whatever the other inputs are.
- R10: Outputs follow the inputs with no clocked delay, and the block has no clock input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| spark_a_i | input | 1 | Ignition pulse, channel A |
| spark_b_i | input | 1 | Ignition pulse, channel B |
| sel_a_i | input | 3 | Binary output index for channel A |
| sel_b_i | input | 3 | Binary output index for channel B |
| mirror_i | input | 2 | Wasted-spark mode: 00 none, 01 4-cyl, 10 6-cyl, 11 8-cyl |
| out_dis_i | input | 1 | High forces all outputs low |
| coil_o | output | 8 | Spark outputs, index 0 is the first output |

## Verification
The assertions are deferred immediate checks. They assume that the inputs have settled by the end of a time step, so that outputs and inputs are compared only after the combinational logic has resolved. The bench changes inputs only between clock edges and compares outputs one nanosecond later, inside the same half period. It never lets an input change and the next comparison fall in the same time step. The sweep covers every combination of pulse pair, selector pair, mirror code and disable level, which is 2048 cases.

// File: rtl/spark_router_pkg.sv
package spark_router_pkg;

    typedef enum logic [1:0] {
        MIR_COP  = 2'b00,
        MIR_CYL4 = 2'b01,
        MIR_CYL6 = 2'b10,
        MIR_CYL8 = 2'b11
    } mirror_mode_e;

    localparam int unsigned HALF_CYL4 = 2;
    localparam int unsigned HALF_CYL6 = 3;
    localparam int unsigned HALF_CYL8 = 4;

endpackage

// File: rtl/spark_steer.sv
module spark_steer #(
    parameter int unsigned N_OUT = 8,
    localparam int unsigned SEL_W = $clog2(N_OUT)
) (
    input  logic             pulse_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [N_OUT-1:0] lines_o
);
    always_comb begin
        lines_o = '0;
        for (int i = 0; i < N_OUT; i++) begin
            if (sel_i == SEL_W'(i)) begin
                lines_o[i] = pulse_i;
            end
        end
    end
endmodule

// File: rtl/spark_mirror.sv
module spark_mirror
    import spark_router_pkg::*;
#(
    parameter int unsigned N_OUT = 8,
    localparam int unsigned SEL_W = $clog2(N_OUT)
) (
    input  logic [N_OUT-1:0] raw_i,
    input  mirror_mode_e     mode_i,
    input  logic             dis_i,
    output logic [N_OUT-1:0] coil_o
);
    logic [SEL_W:0] half;

    always_comb begin
        unique case (mode_i)
            MIR_COP:  half = '0;
            MIR_CYL4: half = (SEL_W+1)'(HALF_CYL4);
            MIR_CYL6: half = (SEL_W+1)'(HALF_CYL6);
            MIR_CYL8: half = (SEL_W+1)'(HALF_CYL8);
            default:  half = '0;
        endcase
    end

    always_comb begin
        for (int i = 0; i < N_OUT; i++) begin
            if ((SEL_W+1)'(i) >= half && (SEL_W+1)'(i) < (half << 1)) begin
                coil_o[i] = raw_i[SEL_W'((SEL_W+1)'(i) - half)];
            end else begin
                coil_o[i] = raw_i[i];
            end
        end
        if (dis_i) begin
            coil_o = '0;
        end
    end
endmodule

// File: rtl/spark_router.sv
module spark_router
    import spark_router_pkg::*;
#(
    parameter int unsigned N_OUT = 8,
    localparam int unsigned SEL_W = $clog2(N_OUT),
    localparam int unsigned N_CH  = 2
) (
    input  logic             spark_a_i,
    input  logic             spark_b_i,
    input  logic [SEL_W-1:0] sel_a_i,
    input  logic [SEL_W-1:0] sel_b_i,
    input  logic [1:0]       mirror_i,
    input  logic             out_dis_i,
    output logic [N_OUT-1:0] coil_o
);
    logic [N_CH-1:0]             pulse;
    logic [N_CH-1:0][SEL_W-1:0]  sel;
    logic [N_CH-1:0][N_OUT-1:0]  lines;
    logic [N_OUT-1:0]            merged;
    mirror_mode_e                mode;

    assign pulse = {spark_b_i, spark_a_i};
    assign sel   = {sel_b_i, sel_a_i};
    assign mode  = mirror_mode_e'(mirror_i);

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        spark_steer #(.N_OUT(N_OUT)) steer_i (
            .pulse_i (pulse[c]),
            .sel_i   (sel[c]),
            .lines_o (lines[c])
        );
    end

    always_comb begin
        merged = '0;
        for (int c = 0; c < N_CH; c++) begin
            merged = merged | lines[c];
        end
    end

    spark_mirror #(.N_OUT(N_OUT)) mirror_i_inst (
        .raw_i  (merged),
        .mode_i (mode),
        .dis_i  (out_dis_i),
        .coil_o (coil_o)
    );
endmodule

// File: rtl/spark_router_chk.sv
module spark_router_chk #(
    parameter int unsigned N_OUT = 8,
    localparam int unsigned SEL_W = $clog2(N_OUT)
) (
    input logic             spark_a_i,
    input logic             spark_b_i,
    input logic [SEL_W-1:0] sel_a_i,
    input logic [SEL_W-1:0] sel_b_i,
    input logic [1:0]       mirror_i,
    input logic             out_dis_i,
    input logic [N_OUT-1:0] coil_o
);
    always_comb begin
        AST_DISABLED_QUIET: assert final (!out_dis_i || coil_o == '0); // R9
        AST_PULSE_A_REACH: assert final (out_dis_i || mirror_i != 2'b00 || !spark_a_i || coil_o[sel_a_i]); // R1
        AST_PULSE_B_REACH: assert final (out_dis_i || mirror_i != 2'b00 || !spark_b_i || coil_o[sel_b_i]); // R2
        AST_COP_AT_MOST_TWO: assert final (mirror_i != 2'b00 || $countones(coil_o) <= 2); // R4
        AST_MIRROR_CYL4: assert final (mirror_i != 2'b01 || (coil_o[2] == coil_o[0] && coil_o[3] == coil_o[1])); // R5
        AST_MIRROR_CYL6: assert final (mirror_i != 2'b10 || (coil_o[5:3] == coil_o[2:0])); // R6
        AST_MIRROR_CYL8: assert final (mirror_i != 2'b11 || (coil_o[7:4] == coil_o[3:0])); // R7
    end
endmodule

bind spark_router spark_router_chk #(.N_OUT(N_OUT)) chk_i (
    .spark_a_i (spark_a_i),
    .spark_b_i (spark_b_i),
    .sel_a_i   (sel_a_i),
    .sel_b_i   (sel_b_i),
    .mirror_i  (mirror_i),
    .out_dis_i (out_dis_i),
    .coil_o    (coil_o)
);

// File: tb/spark_router_tb_top.sv
`timescale 1ns/100ps
module spark_router_tb_top;
    logic       clk = 1'b0;
    logic       spark_a, spark_b, dis;
    logic [2:0] sel_a, sel_b;
    logic [1:0] mir;
    logic [7:0] coil;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    spark_router dut_i (
        .spark_a_i (spark_a),
        .spark_b_i (spark_b),
        .sel_a_i   (sel_a),
        .sel_b_i   (sel_b),
        .mirror_i  (mir),
        .out_dis_i (dis),
        .coil_o    (coil)
    );

    function automatic logic [7:0] model(input logic pa, input logic pb,
        input logic [2:0] sa, input logic [2:0] sb, input logic [1:0] m, input logic d);
        logic [7:0] raw;
        logic [7:0] res;
        int h;
        raw = (8'(pa) << sa) | (8'(pb) << sb);
        h = (m == 2'd1) ? 2 : (m == 2'd2) ? 3 : (m == 2'd3) ? 4 : 0;
        res = raw;
        for (int i = 0; i < 8; i++) begin
            if (i >= h && i < 2*h) res[i] = raw[i-h];
        end
        return d ? 8'h00 : res;
    endfunction

    task automatic check(input string tag, input logic [7:0] exp);
        total++;
        if (coil !== exp) begin
            bad++;
            $display("FAIL %s: coil=%b expected=%b (a=%b b=%b sa=%0d sb=%0d mir=%b dis=%b)",
                     tag, coil, exp, spark_a, spark_b, sel_a, sel_b, mir, dis);
        end
    endtask

    task automatic apply(input logic pa, input logic pb, input logic [2:0] sa,
                         input logic [2:0] sb, input logic [1:0] m, input logic d);
        @(negedge clk);
        spark_a = pa; spark_b = pb; sel_a = sa; sel_b = sb; mir = m; dis = d;
        #1;
    endtask

    initial begin
        spark_a = 1'b1; spark_b = 1'b1; sel_a = 3'd0; sel_b = 3'd5; mir = 2'b00; dis = 1'b1;
        #1;
        check("R9 power-up disabled", 8'h00);

        // R1, R2: single channel routing, every selector code
        for (int s = 0; s < 8; s++) begin
            apply(1'b1, 1'b0, 3'(s), 3'(7-s), 2'b00, 1'b0);
            check("R1 channel A routing", 8'(1) << s);
            apply(1'b0, 1'b1, 3'(7-s), 3'(s), 2'b00, 1'b0);
            check("R2 channel B routing", 8'(1) << s);
        end
        // R3: overlap
        apply(1'b1, 1'b1, 3'd6, 3'd6, 2'b00, 1'b0);
        check("R3 overlap OR", 8'h40);
        // R8: decoder value on mirrored output is replaced, upper outputs kept
        apply(1'b1, 1'b0, 3'd2, 3'd0, 2'b01, 1'b0);
        check("R8 mirrored target ignores decoder", 8'h00);
        apply(1'b0, 1'b1, 3'd0, 3'd6, 2'b01, 1'b0);
        check("R8 upper output kept in 4-cyl", 8'h40);
        apply(1'b1, 1'b0, 3'd7, 3'd0, 2'b10, 1'b0);
        check("R8 upper output kept in 6-cyl", 8'h80);
        // R10: change within one half period, no edge between
        @(posedge clk);
        #0.5;
        spark_a = 1'b1; sel_a = 3'd1; spark_b = 1'b0; mir = 2'b00; dis = 1'b0;
        #0.5;
        check("R10 no clocked delay", 8'h02);
        spark_a = 1'b0;
        #0.5;
        check("R10 falling edge immediate", 8'h00);

        // exhaustive sweep
        for (int d = 0; d < 2; d++) begin
            for (int m = 0; m < 4; m++) begin
                for (int sa = 0; sa < 8; sa++) begin
                    for (int sb = 0; sb < 8; sb++) begin
                        for (int p = 0; p < 4; p++) begin
                            string tag;
                            apply(p[0], p[1], 3'(sa), 3'(sb), 2'(m), d[0]);
                            if (d != 0) tag = "R9 sweep";
                            else if (m == 1) tag = "R5 sweep";
                            else if (m == 2) tag = "R6 sweep";
                            else if (m == 3) tag = "R7 sweep";
                            else if (sa == sb) tag = "R3 sweep";
                            else tag = "R4 sweep";
                            check(tag, model(p[0], p[1], 3'(sa), 3'(sb), 2'(m), d[0]));
                        end
                    end
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule